// File: doc/BRIEF.md
# Aliased Machine Status Register Unit

This block keeps one 64-bit machine status word and makes it reachable through three register views: machine, supervisor and user. The supervisor and user views are restricted windows onto the same storage and do not hold separate copies. A single access port carries one operation per cycle: read, full write, set-bits or clear-bits. The view is chosen by the access address.

Static configuration inputs select either a 64-bit or a 32-bit register width, and say whether supervisor and user modes exist. In 32-bit mode, reads and writes use a packed 32-bit layout. The user and supervisor width fields have no place in that layout and stay untouched. Each view limits writes to its own mask. The previous-privilege field refuses codes of modes that do not exist.

After every update that leaves an interrupt enable set, an interrupt-recheck output goes high for one cycle. This pulse comes from a two-state machine. ST_QUIET is the idle state. It moves to ST_RECHECK on an update whose result has any of bits 3:0 set. ST_RECHECK stays in ST_RECHECK on a further such update and returns to ST_QUIET on any other cycle.

Top module: `xstat_alias_unit`

## Requirements
- R1: Address 0x300 selects the machine view, 0x100 the supervisor view and 0x000 the user view. Any other address with `acc_valid` high drives `acc_illegal` high, returns `acc_rdata` of zero and leaves the storage unchanged.
- R2: At reset the storage holds 2'b11 in bits 12:11 and zeros everywhere else, except for two width fields. The user width field (bits 33:32) and the supervisor width field (bits 35:34) each hold 2'b10 when the width is 64 bits and 2'b01 when it is 32 bits. Each field holds 2'b00 instead when its mode is not supported.
- R3: `acc_op` encodes the operation: 0 is read, 1 is write, 2 is set-bits and 3 is clear-bits. A write replaces the bits inside the view's write mask with the operand. Set-bits ORs the operand into those bits. Clear-bits clears those bits where the operand has ones. All bits outside the mask keep their values.
- R4: The write masks are 0x4000_0000_0000_19BB for the machine view, 0x0000_0000_0000_0133 for the supervisor view and 0x0000_0000_0000_0011 for the user view. No access can change bits 35:32.
- R5: A machine-view read returns the storage ANDed with the read mask 0xC000_000F_0000_19BB. A supervisor-view or user-view read returns the storage unmasked.
- R6: When `cfg_is64` is low, a read returns {32'b0, v[63:62], v[29:0]}, where v is the value the view would return at 64 bits. A write takes its operand from `acc_wdata[31:0]`: bits 31:30 go to storage bits 63:62 and bits 29:0 go to storage bits 29:0. In this mode, storage bits 61:30 never change.
- R7: Bits 12:11 hold the previous-privilege field. An update that would leave 2'b00 there while user mode is unsupported keeps the old field value. An update that would leave 2'b01 there while supervisor mode is unsupported also keeps the old value. The rest of the update still applies.
- R8: `irq_recheck` is high for exactly the cycle after an accepted write, set or clear whose resulting bits 3:0 are non-zero. It is low after reads, after illegal accesses and after updates that leave bits 3:0 at zero.
- R9: `acc_rdata` is combinational and shows the value held before the access. An update is visible from the clock edge that samples the access onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_is64 | input | 1 | 1 selects 64-bit width, 0 selects 32-bit packed layout |
| cfg_has_super | input | 1 | Supervisor mode supported |
| cfg_has_user | input | 1 | User mode supported |
| acc_valid | input | 1 | Access present this cycle |
| acc_op | input | 2 | Operation code (read, write, set, clear) |
| acc_addr | input | 12 | Register address selecting the view |
| acc_wdata | input | 64 | Write or set/clear operand |
| acc_rdata | output | 64 | Read value of the addressed view |
| acc_illegal | output | 1 | Access address matches no view |
| irq_recheck | output | 1 | One-cycle request to re-evaluate pending interrupts |

## Verification
Some properties are checked by assertions on every cycle. Illegal accesses and reads never change the storage. Supervisor-view updates never touch bits outside their mask. The width fields never move after reset. The previous-privilege field never holds a code for a missing mode. The recheck pulse only appears while an interrupt enable is set. Only the bench's sweeps can show the rest. It checks the exact values that result from each operation, view and pattern under all eight configurations, the packed 32-bit read and write layout, the reset encodings of the width fields, and that a read during an update returns the old value.

// File: rtl/xstat_pkg.sv
package xstat_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } xs_op_e;

    typedef enum logic [1:0] {
        VW_NONE = 2'd0,
        VW_MACH = 2'd1,
        VW_SUPV = 2'd2,
        VW_USER = 2'd3
    } xs_view_e;

    typedef enum logic {
        ST_QUIET   = 1'b0,
        ST_RECHECK = 1'b1
    } xs_state_e;

    localparam int unsigned XS_W = 64;
    localparam int unsigned XS_NW = 32;

    localparam logic [XS_W-1:0] MACH_WMASK  = 64'h4000_0000_0000_19BB;
    localparam logic [XS_W-1:0] SUPV_WMASK  = 64'h0000_0000_0000_0133;
    localparam logic [XS_W-1:0] USER_WMASK  = 64'h0000_0000_0000_0011;
    localparam logic [XS_W-1:0] MACH_RMASK  = 64'hC000_000F_0000_19BB;
    // storage bits reachable from the packed 32-bit layout
    localparam logic [XS_W-1:0] NARROW_REACH = 64'hC000_0000_3FFF_FFFF;

    localparam logic [1:0] WCODE_64 = 2'b10;
    localparam logic [1:0] WCODE_32 = 2'b01;
    localparam logic [1:0] PRIV_U   = 2'b00;
    localparam logic [1:0] PRIV_S   = 2'b01;

    function automatic logic [XS_NW-1:0] pack_narrow(input logic [XS_W-1:0] v);
        return {v[63:62], v[29:0]};
    endfunction

    function automatic logic [XS_W-1:0] unpack_narrow(input logic [XS_NW-1:0] w);
        return {w[31:30], 32'b0, w[29:0]};
    endfunction

endpackage

// File: rtl/xstat_view_sel.sv
module xstat_view_sel
    import xstat_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] MACH_ADDR = 12'h300,
    parameter logic [ADDR_W-1:0] SUPV_ADDR = 12'h100,
    parameter logic [ADDR_W-1:0] USER_ADDR = 12'h000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is64,
    output xs_view_e          view,
    output logic [XS_W-1:0]   wmask
);
    logic hit_m, hit_s, hit_u;
    logic [XS_W-1:0] base_mask;

    assign hit_m = (addr == MACH_ADDR);
    assign hit_s = (addr == SUPV_ADDR);
    assign hit_u = (addr == USER_ADDR);

    always_comb begin
        unique case (1'b1)
            hit_m:   begin view = VW_MACH; base_mask = MACH_WMASK; end
            hit_s:   begin view = VW_SUPV; base_mask = SUPV_WMASK; end
            hit_u:   begin view = VW_USER; base_mask = USER_WMASK; end
            default: begin view = VW_NONE; base_mask = '0;         end
        endcase
    end

    // in the packed layout only the reachable bits may be written
    assign wmask = is64 ? base_mask : (base_mask & NARROW_REACH);

    always_comb begin
        assert_view_unique_R1: assert ($onehot0({hit_m, hit_s, hit_u}));
    end

endmodule

// File: rtl/xstat_update.sv
module xstat_update
    import xstat_pkg::*;
(
    input  logic [XS_W-1:0] cur,
    input  logic [XS_W-1:0] operand,
    input  xs_op_e          op,
    input  logic [XS_W-1:0] wmask,
    input  logic            has_super,
    input  logic            has_user,
    output logic [XS_W-1:0] nxt
);
    logic [XS_W-1:0] raw;
    logic [XS_W-1:0] merged;
    logic            bad_priv;

    always_comb begin
        unique case (op)
            OP_WRITE: raw = operand;
            OP_SET:   raw = cur | operand;
            OP_CLEAR: raw = cur & ~operand;
            default:  raw = cur;
        endcase
    end

    assign merged = (raw & wmask) | (cur & ~wmask);

    // previous-privilege legality (R7)
    assign bad_priv = ((merged[12:11] == PRIV_U) && !has_user) ||
                      ((merged[12:11] == PRIV_S) && !has_super);

    always_comb begin
        nxt = merged;
        if (bad_priv) nxt[12:11] = cur[12:11];
    end

endmodule

// File: rtl/xstat_alias_unit.sv
module xstat_alias_unit
    import xstat_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter logic [63:0] RST_LOW = 64'h0000_0000_0000_1800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_is64,
    input  logic              cfg_has_super,
    input  logic              cfg_has_user,
    input  logic              acc_valid,
    input  logic [1:0]        acc_op,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [63:0]       acc_wdata,
    output logic [63:0]       acc_rdata,
    output logic              acc_illegal,
    output logic              irq_recheck
);
    localparam logic [ADDR_W-1:0] A_MACH = ADDR_W'(12'h300);
    localparam logic [ADDR_W-1:0] A_SUPV = ADDR_W'(12'h100);
    localparam logic [ADDR_W-1:0] A_USER = ADDR_W'(12'h000);

    logic [XS_W-1:0] store;
    logic [XS_W-1:0] store_nxt;
    logic [XS_W-1:0] reset_val;
    logic [XS_W-1:0] operand;
    logic [XS_W-1:0] wmask;
    logic [XS_W-1:0] rd_src;
    logic [1:0]      wcode;
    logic            do_update;
    xs_view_e        view;
    xs_op_e          op_q;
    xs_state_e       state, state_nxt;

    assign op_q = xs_op_e'(acc_op);

    xstat_view_sel #(
        .ADDR_W   (ADDR_W),
        .MACH_ADDR(A_MACH),
        .SUPV_ADDR(A_SUPV),
        .USER_ADDR(A_USER)
    ) u_view_sel (
        .addr (acc_addr),
        .is64 (cfg_is64),
        .view (view),
        .wmask(wmask)
    );

    assign operand = cfg_is64 ? acc_wdata : unpack_narrow(acc_wdata[XS_NW-1:0]);

    xstat_update u_update (
        .cur      (store),
        .operand  (operand),
        .op       (op_q),
        .wmask    (wmask),
        .has_super(cfg_has_super),
        .has_user (cfg_has_user),
        .nxt      (store_nxt)
    );

    assign acc_illegal = acc_valid && (view == VW_NONE);
    assign do_update   = acc_valid && (view != VW_NONE) && (op_q != OP_READ);

    // reset image: width fields follow the configuration
    assign wcode = cfg_is64 ? WCODE_64 : WCODE_32;
    always_comb begin
        reset_val        = RST_LOW;
        reset_val[35:32] = {cfg_has_super ? wcode : 2'b00,
                            cfg_has_user  ? wcode : 2'b00};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         store <= reset_val;
        else if (do_update) store <= store_nxt;
    end

    // recheck state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_QUIET;
        else        state <= state_nxt;
    end

    // recheck state machine: next state and output
    always_comb begin
        unique case (state)
            ST_QUIET:   state_nxt = (do_update && (store_nxt[3:0] != 4'd0)) ? ST_RECHECK : ST_QUIET;
            ST_RECHECK: state_nxt = (do_update && (store_nxt[3:0] != 4'd0)) ? ST_RECHECK : ST_QUIET;
            default:    state_nxt = ST_QUIET;
        endcase
    end

    assign irq_recheck = (state == ST_RECHECK);

    // read path
    assign rd_src = (view == VW_MACH) ? (store & MACH_RMASK) : store;
    always_comb begin
        if (!acc_valid || view == VW_NONE) acc_rdata = '0;
        else if (cfg_is64)                 acc_rdata = rd_src;
        else                               acc_rdata = {32'b0, pack_narrow(rd_src)};
    end

    assert_illegal_keeps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_illegal) |=> $stable(store));

    assert_read_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_op == 2'd0) |=> $stable(store));

    assert_width_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(store[35:32]));

    assert_supv_confined_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr == A_SUPV) |=>
            ((store & ~SUPV_WMASK) == ($past(store) & ~SUPV_WMASK)));

    assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_is64 |=> $stable(store[61:30]));

    assert_no_user_priv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_has_user |-> (store[12:11] != PRIV_U));

    assert_no_supv_priv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_has_super |-> (store[12:11] != PRIV_S));

    assert_recheck_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_recheck |-> (store[3:0] != 4'd0));

endmodule

// File: tb/xstat_alias_unit_bench.sv
`timescale 1ns/1ps
module xstat_alias_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_is64 = 1'b1;
    logic        cfg_has_super = 1'b1;
    logic        cfg_has_user = 1'b1;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_op = 2'd0;
    logic [11:0] acc_addr = 12'h0;
    logic [63:0] acc_wdata = 64'h0;
    logic [63:0] acc_rdata;
    logic        acc_illegal;
    logic        irq_recheck;

    int n_checks = 0;
    int n_fail = 0;
    logic [63:0] mdl;

    always #4 clk = ~clk;

    xstat_alias_unit u_xstat_alias_unit (
        .clk(clk), .rst_n(rst_n), .cfg_is64(cfg_is64),
        .cfg_has_super(cfg_has_super), .cfg_has_user(cfg_has_user),
        .acc_valid(acc_valid), .acc_op(acc_op), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_illegal(acc_illegal), .irq_recheck(irq_recheck)
    );

    function automatic logic [63:0] narrow_read(input logic [63:0] v);
        return ((v >> 32) & 64'hC000_0000) | (v & 64'h3FFF_FFFF);
    endfunction

    function automatic logic [63:0] narrow_write(input logic [63:0] w);
        return ((w & 64'hC000_0000) << 32) | (w & 64'h3FFF_FFFF);
    endfunction

    function automatic int view_of(input logic [11:0] a);
        if (a == 12'h300) return 0;
        if (a == 12'h100) return 1;
        if (a == 12'h000) return 2;
        return 3;
    endfunction

    function automatic logic [63:0] view_wmask(input int v);
        case (v)
            0: return 64'h4000_0000_0000_19BB;
            1: return 64'h0000_0000_0000_0133;
            2: return 64'h0000_0000_0000_0011;
            default: return 64'h0;
        endcase
    endfunction

    function automatic logic [63:0] exp_read(input logic [63:0] st, input int v);
        logic [63:0] r;
        if (v == 3) return 64'h0;
        r = (v == 0) ? (st & 64'hC000_000F_0000_19BB) : st;
        return cfg_is64 ? r : narrow_read(r);
    endfunction

    function automatic logic [63:0] exp_next(input logic [63:0] old, input logic [1:0] op,
                                             input int v, input logic [63:0] d);
        logic [63:0] wm, opnd, raw, nv;
        if (v == 3 || op == 2'd0) return old;
        wm = view_wmask(v);
        if (!cfg_is64) wm = wm & 64'hC000_0000_3FFF_FFFF;
        opnd = cfg_is64 ? d : narrow_write({32'h0, d[31:0]});
        case (op)
            2'd1: raw = opnd;
            2'd2: raw = old | opnd;
            default: raw = old & ~opnd;
        endcase
        nv = (raw & wm) | (old & ~wm);
        if ((nv[12:11] == 2'b00 && !cfg_has_user) || (nv[12:11] == 2'b01 && !cfg_has_super))
            nv[12:11] = old[12:11];
        return nv;
    endfunction

    function automatic logic [63:0] pattern(input int i);
        case (i)
            0: return 64'hFFFF_FFFF_FFFF_FFFF;
            1: return 64'h0000_0000_0000_0000;
            2: return 64'hAAAA_AAAA_AAAA_AAAA;
            3: return 64'h5555_5555_5555_5555;
            4: return 64'h0000_0000_0000_0809;
            5: return 64'h0000_0000_0000_1000;
            default: return 64'h4000_0000_C000_0003;
        endcase
    endfunction

    function automatic logic [11:0] addr_of(input int i);
        case (i)
            0: return 12'h300;
            1: return 12'h100;
            2: return 12'h000;
            3: return 12'h200;
            default: return 12'h301;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] op, input logic [11:0] a, input logic [63:0] d,
                          output logic [63:0] rd, output logic ill);
        @(negedge clk);
        acc_valid = 1'b1; acc_op = op; acc_addr = a; acc_wdata = d;
        #1;
        rd = acc_rdata; ill = acc_illegal;
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic is64, input logic sup, input logic usr);
        logic [1:0] wc;
        @(negedge clk);
        rst_n = 1'b0;
        cfg_is64 = is64; cfg_has_super = sup; cfg_has_user = usr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wc = is64 ? 2'b10 : 2'b01;
        mdl = 64'h0000_0000_0000_1800;
        mdl[35:34] = sup ? wc : 2'b00;
        mdl[33:32] = usr ? wc : 2'b00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] rd, pre, d;
        logic ill;
        int v;
        string tag;
        for (int c = 0; c < 8; c++) begin
            do_reset(c[2], c[1], c[0]);
            // R2 reset image seen through the supervisor view (raw storage)
            access(2'd0, 12'h100, 64'h0, rd, ill);
            chk("R2 reset image", rd, exp_read(mdl, 1));
            chk("R8 no pulse after read", {63'b0, irq_recheck}, 64'h0);
            for (int ai = 0; ai < 5; ai++) begin
                for (int op = 1; op < 4; op++) begin
                    for (int pi = 0; pi < 7; pi++) begin
                        d = pattern(pi);
                        v = view_of(addr_of(ai));
                        pre = mdl;
                        access(op[1:0], addr_of(ai), d, rd, ill);
                        mdl = exp_next(pre, op[1:0], v, d);
                        chk("R1 illegal flag", {63'b0, ill}, {63'b0, v == 3});
                        chk("R9 old value during update", rd, exp_read(pre, v));
                        chk("R8 recheck pulse", {63'b0, irq_recheck},
                            {63'b0, (v != 3) && (mdl[3:0] != 4'd0)});
                        if (v == 3)                tag = "R1 storage kept";
                        else if (pi == 4 || pi == 5) tag = "R7 privilege field";
                        else if (v != 0)           tag = "R4 view mask";
                        else if (!cfg_is64)        tag = "R6 packed write";
                        else                       tag = "R3 machine update";
                        access(2'd0, 12'h300, 64'h0, rd, ill);
                        chk(tag, rd, exp_read(mdl, 0));
                        access(2'd0, 12'h100, 64'h0, rd, ill);
                        chk("R5 supervisor read", rd, exp_read(mdl, 1));
                        access(2'd0, 12'h000, 64'h0, rd, ill);
                        chk(cfg_is64 ? "R5 user read" : "R6 packed read", rd, exp_read(mdl, 2));
                    end
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule